// File: doc/BRIEF.md
# Pad Output Driver with Masked Bit Updates

This block holds the output data bits and the per-pin drive modes for a parameterizable bank of general-purpose pins, 64 by default. It turns them into the two vectors that a pad ring expects: the value to place on each pad, and an enable for each pad's output buffer. Each pin can be an input, a push-pull output, or one of two open-drain flavours. One flavour can only pull the pad high. The other can only pull it low.

Software or a bus adapter reaches the block through one simple write port. The port carries an operation code, a word index and 32 data bits. The output bits can be replaced a whole word at a time. They can also be changed bit by bit through set, clear and toggle actions, so one pin changes without a read-modify-write of the others. A combinational read port returns the stored mode and output words.

Operation codes on `wr_op_i` and `rd_op_i` are: 0 mode word, 1 output word, 2 set, 3 clear, 4 toggle. Codes 5 to 7 are unused.

Top module: `gpo_driver`

## Requirements
- R1: After reset every mode field is 0 and every output bit is 0, so `pad_oe_o` and `pad_out_o` are all zero until the first accepted write.
- R2: Mode word k (0 ≤ k < ceil(NUM_PINS/16)) holds 2-bit mode fields for pins 16k to 16k+15, with pin 16k+j at bits 2j+1:2j. A write with op 0 replaces the word, and a read with op 0 returns it.
- R3: Mode 0 (input): the pin's `pad_oe_o` bit is 0 and its `pad_out_o` bit is 0.
- R4: Mode 1 (push-pull): `pad_oe_o` is 1 and `pad_out_o` equals the pin's output bit.
- R5: Mode 2 (drive-high only): `pad_oe_o` equals the output bit and `pad_out_o` is 1.
- R6: Mode 3 (drive-low only): `pad_oe_o` equals the inverted output bit and `pad_out_o` is 0.
- R7: Output word k holds the bits of pins 32k to 32k+31, pin 32k+b at bit b. A write with op 1 replaces the word, and a read with op 1 returns it.
- R8: A set write (op 2) ORs the data into the addressed output word. Bits written as 0 keep their value.
- R9: A clear write (op 3) ANDs the addressed output word with the inverted data. Bits written as 0 keep their value.
- R10: A toggle write (op 4) XORs the data into the addressed output word. Bits written as 0 keep their value.
- R11: Set, clear and toggle store nothing of their own and leave the mode words untouched. Reads with ops 2, 3, 4 and with unused codes 5 to 7 return 0.
- R12: A write whose index is beyond the last word of its kind, or whose op is 5 to 7, changes no state. A read beyond the last word returns 0.
- R13: A write takes effect on the clock edge where `wr_en_i` is 1 and shows on the pad outputs right after that edge. With `wr_en_i` at 0 nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_op_i | input | 3 | Write operation code |
| wr_idx_i | input | IDX_W (3 by default) | Word index of the write |
| wr_data_i | input | 32 | Write data or bit mask |
| rd_op_i | input | 3 | Read operation code |
| rd_idx_i | input | IDX_W (3 by default) | Word index of the read |
| rd_data_o | output | 32 | Read data, combinational |
| pad_out_o | output | NUM_PINS | Value presented to each pad |
| pad_oe_o | output | NUM_PINS | Output-buffer enable for each pad, 1 drives |

## Verification
The bench builds the block with the default of 64 pins. That gives four mode words and two output words, both fully populated. The three-bit index can then point past the last output word (indices 2 to 7) and past the last mode word (indices 4 to 7), so the drop paths for both kinds of word are reached. With pins on both sides of the word 0/1 boundary, every mode-word and output-word lane is exercised.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

  localparam int unsigned WORD_W         = 32;
  localparam int unsigned MODE_FIELD_W   = 2;
  localparam int unsigned PINS_PER_MODE  = WORD_W / MODE_FIELD_W;
  localparam int unsigned PINS_PER_OUT   = WORD_W;

  typedef enum logic [2:0] {
    OP_MODE   = 3'd0,
    OP_OUT    = 3'd1,
    OP_SET    = 3'd2,
    OP_CLR    = 3'd3,
    OP_TGL    = 3'd4
  } gpo_op_e;

  typedef enum logic [1:0] {
    PM_INPUT      = 2'd0,
    PM_PUSH_PULL  = 2'd1,
    PM_HIGH_ONLY  = 2'd2,
    PM_LOW_ONLY   = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drive_t;

  // New value of an output word for a given write action.
  function automatic logic [WORD_W-1:0] masked_update(
    input gpo_op_e           op,
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] data
  );
    logic [WORD_W-1:0] nxt;
    case (op)
      OP_OUT:  nxt = data;
      OP_SET:  nxt = cur | data;
      OP_CLR:  nxt = cur & ~data;
      OP_TGL:  nxt = cur ^ data;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  // Pad drive pair for a mode field and an output bit.
  function automatic pad_drive_t encode_pad(input pin_mode_e mode, input logic out_bit);
    pad_drive_t d;
    case (mode)
      PM_PUSH_PULL: begin d.oe = 1'b1;     d.val = out_bit; end
      PM_HIGH_ONLY: begin d.oe = out_bit;  d.val = 1'b1;    end
      PM_LOW_ONLY:  begin d.oe = ~out_bit; d.val = 1'b0;    end
      default:      begin d.oe = 1'b0;     d.val = 1'b0;    end
    endcase
    return d;
  endfunction

  // Bits of word w that belong to an existing pin.
  function automatic logic [WORD_W-1:0] live_mask(
    input int unsigned w,
    input int unsigned pins_per_word,
    input int unsigned bits_per_pin,
    input int unsigned num_pins
  );
    logic [WORD_W-1:0] m;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      m[i] = ((w * pins_per_word) + (i / bits_per_pin)) < num_pins;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpo_wr_decode.sv
module gpo_wr_decode
  import gpo_pkg::*;
#(
  parameter int unsigned MODE_WORDS = 4,
  parameter int unsigned OUT_WORDS  = 2,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                  wr_en,
  input  gpo_op_e               wr_op,
  input  logic [IDX_W-1:0]      wr_idx,
  output logic [MODE_WORDS-1:0] mode_we,
  output logic [OUT_WORDS-1:0]  out_we,
  output logic                  wr_drop
);

  logic is_mode_op;
  logic is_out_op;

  always_comb begin
    is_mode_op = (wr_op == OP_MODE);
    is_out_op  = (wr_op == OP_OUT) || (wr_op == OP_SET) ||
                 (wr_op == OP_CLR) || (wr_op == OP_TGL);
  end

  for (genvar w = 0; w < MODE_WORDS; w++) begin : g_mode_sel
    assign mode_we[w] = wr_en && is_mode_op && (wr_idx == IDX_W'(w));
  end

  for (genvar w = 0; w < OUT_WORDS; w++) begin : g_out_sel
    assign out_we[w] = wr_en && is_out_op && (wr_idx == IDX_W'(w));
  end

  assign wr_drop = wr_en && !(|mode_we) && !(|out_we);

endmodule

// File: rtl/gpo_mode_bank.sv
module gpo_mode_bank
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 64,
  parameter int unsigned MODE_WORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [MODE_WORDS-1:0]          word_we,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [MODE_WORDS*WORD_W-1:0]   mode_words
);

  for (genvar w = 0; w < MODE_WORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] LIVE = live_mask(w, PINS_PER_MODE, MODE_FIELD_W, NUM_PINS);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_we[w]) begin
        word_q <= wr_data & LIVE;
      end
    end

    assign mode_words[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/gpo_out_bank.sv
module gpo_out_bank
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 64,
  parameter int unsigned OUT_WORDS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [OUT_WORDS-1:0]          word_we,
  input  gpo_op_e                       wr_op,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [OUT_WORDS*WORD_W-1:0]   out_words
);

  for (genvar w = 0; w < OUT_WORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] LIVE = live_mask(w, PINS_PER_OUT, 1, NUM_PINS);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_nxt;

    assign word_nxt = masked_update(wr_op, word_q, wr_data) & LIVE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_we[w]) begin
        word_q <= word_nxt;
      end
    end

    assign out_words[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/gpo_pad_encode.sv
module gpo_pad_encode
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64
) (
  input  logic [NUM_PINS*MODE_FIELD_W-1:0] mode_flat,
  input  logic [NUM_PINS-1:0]              out_flat,
  output logic [NUM_PINS-1:0]              pad_out,
  output logic [NUM_PINS-1:0]              pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pad_drive_t drv;
    assign drv        = encode_pad(pin_mode_e'(mode_flat[p*MODE_FIELD_W +: MODE_FIELD_W]), out_flat[p]);
    assign pad_out[p] = drv.val;
    assign pad_oe[p]  = drv.oe;
  end

endmodule

// File: rtl/gpo_driver.sv
module gpo_driver
  import gpo_pkg::*;
#(
  parameter  int unsigned NUM_PINS   = 64,
  localparam int unsigned MODE_WORDS = (NUM_PINS + PINS_PER_MODE - 1) / PINS_PER_MODE,
  localparam int unsigned OUT_WORDS  = (NUM_PINS + PINS_PER_OUT - 1) / PINS_PER_OUT,
  localparam int unsigned IDX_W      = $clog2(MODE_WORDS) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_op_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [2:0]          rd_op_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);

  gpo_op_e                         wr_op;
  gpo_op_e                         rd_op;
  logic [MODE_WORDS-1:0]           mode_we;
  logic [OUT_WORDS-1:0]            out_we;
  logic                            wr_drop;
  logic [MODE_WORDS*WORD_W-1:0]    mode_words;
  logic [OUT_WORDS*WORD_W-1:0]     out_words;
  logic [NUM_PINS*MODE_FIELD_W-1:0] mode_flat;
  logic [NUM_PINS-1:0]             out_flat;

  assign wr_op = gpo_op_e'(wr_op_i);
  assign rd_op = gpo_op_e'(rd_op_i);

  gpo_wr_decode #(
    .MODE_WORDS (MODE_WORDS),
    .OUT_WORDS  (OUT_WORDS),
    .IDX_W      (IDX_W)
  ) u_decode (
    .wr_en   (wr_en_i),
    .wr_op   (wr_op),
    .wr_idx  (wr_idx_i),
    .mode_we (mode_we),
    .out_we  (out_we),
    .wr_drop (wr_drop)
  );

  gpo_mode_bank #(
    .NUM_PINS   (NUM_PINS),
    .MODE_WORDS (MODE_WORDS)
  ) u_modes (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .word_we    (mode_we),
    .wr_data    (wr_data_i),
    .mode_words (mode_words)
  );

  gpo_out_bank #(
    .NUM_PINS  (NUM_PINS),
    .OUT_WORDS (OUT_WORDS)
  ) u_outs (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .word_we   (out_we),
    .wr_op     (wr_op),
    .wr_data   (wr_data_i),
    .out_words (out_words)
  );

  assign mode_flat = mode_words[NUM_PINS*MODE_FIELD_W-1:0];
  assign out_flat  = out_words[NUM_PINS-1:0];

  gpo_pad_encode #(
    .NUM_PINS (NUM_PINS)
  ) u_pads (
    .mode_flat (mode_flat),
    .out_flat  (out_flat),
    .pad_out   (pad_out_o),
    .pad_oe    (pad_oe_o)
  );

  // Readback: stored words only; actions and unused codes read as zero.
  always_comb begin
    rd_data_o = '0;
    if (rd_op == OP_MODE) begin
      for (int w = 0; w < MODE_WORDS; w++) begin
        if (rd_idx_i == IDX_W'(w)) rd_data_o = mode_words[w*WORD_W +: WORD_W];
      end
    end else if (rd_op == OP_OUT) begin
      for (int w = 0; w < OUT_WORDS; w++) begin
        if (rd_idx_i == IDX_W'(w)) rd_data_o = out_words[w*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/gpo_driver_chk.sv
module gpo_driver_chk
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [2:0]                       wr_op,
  input logic                             wr_drop,
  input logic [NUM_PINS*MODE_FIELD_W-1:0] mode_bits,
  input logic [NUM_PINS-1:0]              out_bits,
  input logic [NUM_PINS-1:0]              pad_out,
  input logic [NUM_PINS-1:0]              pad_oe
);

  logic any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     any_wr <= 1'b0;
    else if (wr_en) any_wr <= 1'b1;
  end

  a_r1_quiet_until_write: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |-> (pad_oe == '0) && (pad_out == '0) && (out_bits == '0));

  a_r8_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_SET) |=> (($past(out_bits) & ~out_bits) == '0));

  a_r9_clear_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_CLR) |=> ((out_bits & ~$past(out_bits)) == '0));

  a_r11_action_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_op == OP_SET || wr_op == OP_CLR || wr_op == OP_TGL)) |=> $stable(mode_bits));

  a_r12_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ($stable(mode_bits) && $stable(out_bits)));

  a_r13_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_bits) && $stable(out_bits)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] m;
    assign m = mode_bits[p*MODE_FIELD_W +: MODE_FIELD_W];

    a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'd0) |-> (!pad_oe[p] && !pad_out[p]));

    a_r4_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'd1) |-> (pad_oe[p] && (pad_out[p] == out_bits[p])));

    a_r5_high_only: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'd2) |-> (pad_out[p] && (pad_oe[p] == out_bits[p])));

    a_r6_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'd3) |-> (!pad_out[p] && (pad_oe[p] != out_bits[p])));
  end

endmodule

bind gpo_driver gpo_driver_chk #(
  .NUM_PINS (NUM_PINS)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .wr_en     (wr_en_i),
  .wr_op     (wr_op_i),
  .wr_drop   (wr_drop),
  .mode_bits (mode_flat),
  .out_bits  (out_flat),
  .pad_out   (pad_out_o),
  .pad_oe    (pad_oe_o)
);

// File: tb/gpo_driver_test.sv
`timescale 1ns/1ps
module gpo_driver_test;

  localparam int NP    = 64;
  localparam int MW    = 4;
  localparam int OW    = 2;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_op = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_op = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0] m_mode [NP];
  logic       m_out  [NP];

  always #4 clk = ~clk;

  gpo_driver #(.NUM_PINS(NP)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_op_i   (wr_op),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_op_i   (rd_op),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model of a write, restated per pin.
  task automatic model_write(input logic [2:0] op, input int idx, input logic [31:0] d);
    if (op == 3'd0 && idx < MW) begin
      for (int j = 0; j < 16; j++) m_mode[idx*16 + j] = d[2*j +: 2];
    end else if (op >= 3'd1 && op <= 3'd4 && idx < OW) begin
      for (int b = 0; b < 32; b++) begin
        case (op)
          3'd1: m_out[idx*32 + b] = d[b];
          3'd2: if (d[b]) m_out[idx*32 + b] = 1'b1;
          3'd3: if (d[b]) m_out[idx*32 + b] = 1'b0;
          default: if (d[b]) m_out[idx*32 + b] = ~m_out[idx*32 + b];
        endcase
      end
    end
  endtask

  task automatic do_write(input logic [2:0] op, input int idx, input logic [31:0] d, input bit en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_op = op; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) model_write(op, idx, d);
  endtask

  task automatic do_read(input logic [2:0] op, input int idx, output logic [31:0] d);
    rd_op = op; rd_idx = IW'(idx);
    #1;
    d = rd_data;
  endtask

  task automatic check_pads(input string req);
    logic [NP-1:0] e_val, e_oe;
    for (int p = 0; p < NP; p++) begin
      case (m_mode[p])
        2'd0: begin e_oe[p] = 1'b0;        e_val[p] = 1'b0;     end
        2'd1: begin e_oe[p] = 1'b1;        e_val[p] = m_out[p]; end
        2'd2: begin e_oe[p] = m_out[p];    e_val[p] = 1'b1;     end
        default: begin e_oe[p] = !m_out[p]; e_val[p] = 1'b0;    end
      endcase
    end
    check({req, " pad_oe"}, 64'(pad_oe), 64'(e_oe));
    check({req, " pad_out"}, 64'(pad_out), 64'(e_val));
  endtask

  task automatic check_words(input string req);
    logic [31:0] got, exp;
    for (int w = 0; w < MW; w++) begin
      for (int j = 0; j < 16; j++) exp[2*j +: 2] = m_mode[w*16 + j];
      do_read(3'd0, w, got);
      check({req, " mode word"}, 64'(got), 64'(exp));
    end
    for (int w = 0; w < OW; w++) begin
      for (int b = 0; b < 32; b++) exp[b] = m_out[w*32 + b];
      do_read(3'd1, w, got);
      check({req, " out word"}, 64'(got), 64'(exp));
    end
  endtask

  task automatic t_reset;
    check_pads("R1");
    check_words("R1");
  endtask

  task automatic t_mode_layout;
    logic [31:0] got;
    do_write(3'd0, 1, 32'h1B1B_E4E4);
    do_read(3'd0, 1, got);
    check("R2 mode word 1", 64'(got), 64'h1B1B_E4E4);
    do_write(3'd0, 3, 32'hC000_0001);
    check_words("R2");
    check_pads("R2");
  endtask

  task automatic t_modes;
    do_write(3'd0, 0, 32'h5555_5555);
    do_write(3'd1, 0, 32'hA5A5_0F0F);
    check_pads("R4 push-pull");
    do_write(3'd0, 0, 32'hAAAA_AAAA);
    check_pads("R5 drive-high-only");
    do_write(3'd0, 0, 32'hFFFF_FFFF);
    check_pads("R6 drive-low-only");
    do_write(3'd0, 0, 32'h0000_0000);
    check_pads("R3 input");
    check("R3 pins 0-15 oe", 64'(pad_oe[15:0]), 64'h0);
    do_write(3'd0, 0, 32'hE4E4_E4E4);
    check_pads("R3 R4 R5 R6 mixed");
  endtask

  task automatic t_full_out;
    do_write(3'd0, 2, 32'h5555_5555);
    do_write(3'd0, 3, 32'h5555_5555);
    do_write(3'd1, 1, 32'hDEAD_BEEF);
    check("R7 pins 32-63 push-pull", 64'(pad_out[63:32]), 64'hDEAD_BEEF);
    check_words("R7");
  endtask

  task automatic t_set_clr_tgl;
    do_write(3'd1, 0, 32'h0F0F_0F0F);
    do_write(3'd2, 0, 32'h8000_0011);
    check_words("R8 set");
    check_pads("R8 set");
    do_write(3'd3, 0, 32'h0000_0101);
    check_words("R9 clear");
    check_pads("R9 clear");
    do_write(3'd4, 1, 32'hFFFF_0000);
    check_words("R10 toggle");
    do_write(3'd4, 1, 32'h0000_0001);
    check_pads("R10 toggle");
  endtask

  task automatic t_action_reads;
    logic [31:0] got;
    for (int op = 2; op < 8; op++) begin
      do_read(3'(op), 0, got);
      check("R11 action/unused read", 64'(got), 64'h0);
    end
    do_write(3'd2, 1, 32'hFFFF_FFFF);
    do_write(3'd3, 0, 32'hFFFF_FFFF);
    check_words("R11 modes untouched");
  endtask

  task automatic t_out_of_range;
    logic [31:0] got;
    do_write(3'd1, 2, 32'h1234_5678);
    do_write(3'd2, 7, 32'hFFFF_FFFF);
    do_write(3'd0, 4, 32'hFFFF_FFFF);
    do_write(3'd6, 0, 32'hFFFF_FFFF);
    check_words("R12 drop");
    check_pads("R12 drop");
    do_read(3'd1, 3, got);
    check("R12 out read past end", 64'(got), 64'h0);
    do_read(3'd0, 5, got);
    check("R12 mode read past end", 64'(got), 64'h0);
  endtask

  task automatic t_no_enable;
    do_write(3'd1, 0, 32'h1357_9BDF, 1'b0);
    do_write(3'd0, 0, 32'h0000_0000, 1'b0);
    check_words("R13 idle");
    check_pads("R13 idle");
    do_write(3'd4, 0, 32'h0000_0003);
    check_pads("R13 visible next edge");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin m_mode[p] = 2'd0; m_out[p] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_layout();
    t_modes();
    t_full_out();
    t_set_clr_tgl();
    t_action_reads();
    t_out_of_range();
    t_no_enable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule